// File: doc/BRIEF.md
# IR Receive Echo Blanking and Start Gate

This block sits on the last stretch of an infrared receive path, between the demodulator and the serial RXD line read by the host UART. A local transmitter shares the same optical window, so its LED light would come straight back in as received data. When echo blanking is enabled, the block holds RXD at its idle high level while the LEDs are lit. It keeps holding it for a fixed recovery window after they go dark, and only then lets received bits through.

A second gate serves remote-control reception. In that mode the line can be told to stay idle until the demodulator first reports a valid IR signal. From then on data flows until the receiver is disabled. Disabling the receiver also re-arms the gate for the next session. An eager setting skips the wait and passes data at once. The three control bits are loaded through a single write strobe and all clear on reset. RXD is registered, so it follows the receive bit one clock later.

Top module: `irg_rx_gate`

## Requirements
- R1: With echo blanking enabled, a cycle in which `led_on` is 1 makes `rxd` read 1 after the next clock edge.
- R2: After the last cycle with `led_on` at 1, blanking continues for HOLD_CYC further clock edges (CLK_HZ·HOLD_NS/1e9, which is 1600 cycles or 8 µs at 200 MHz). On the edge after that, `rxd` again takes the value of `rx_raw`.
- R3: If `led_on` returns to 1 before the recovery window ends, the window restarts at its full length from the new last LED cycle.
- R4: With echo blanking disabled, `rx_raw` reaches `rxd` while `led_on` is 1.
- R5: After reset, `rxd` is 1 and all three control bits (blanking, remote mode, eager) are 0.
- R6: In remote mode with eager at 0, `rxd` stays 1 until the first cycle in which `sig_valid` is 1 while enabled. That cycle and later ones pass `rx_raw`.
- R7: In remote mode with eager at 1, `rx_raw` reaches `rxd` without any valid strobe.
- R8: While `rx_en` is 0, `rxd` is 1. Any low cycle of `rx_en` re-arms the remote-mode start gate.
- R9: Outside remote mode, `sig_valid` has no effect on `rxd`.
- R10: `cfg_we` at 1 loads `cfg_blank`, `cfg_remote` and `cfg_eager` on the clock edge. The new values govern `rxd` from the following cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_blank | input | 1 | Echo blanking enable value |
| cfg_remote | input | 1 | Remote-control mode value |
| cfg_eager | input | 1 | Pass immediately in remote mode (1) or wait for first valid signal (0) |
| rx_raw | input | 1 | Demodulated receive bit |
| led_on | input | 1 | Transmit LEDs are lit |
| sig_valid | input | 1 | Demodulator reports a valid IR signal this cycle |
| rx_en | input | 1 | Receiver enable |
| rxd | output | 1 | Gated serial receive output, idle high |

## Verification
The hardest state to reach is the exact edge where the recovery window runs out. The window is long, and random LED activity either keeps reloading it or leaves it far behind. Directed runs light the LEDs briefly, hold `rx_raw` at 0, and count to the last blanked cycle and the first open one. Another run re-lights the LEDs inside the window to expose a missing reload. Random phases toggle `led_on` slowly and drop `rx_en` rarely, so that windows expire and the start gate is re-armed mid-stream under every control combination.

// File: rtl/irg_pkg.sv
`timescale 1ns/1ps
package irg_pkg;
   typedef struct packed {
      logic blank;
      logic remote;
      logic eager;
   } irg_ctrl_t;

   localparam irg_ctrl_t IRG_CTRL_RST = '{blank: 1'b0, remote: 1'b0, eager: 1'b0};
endpackage

// File: rtl/irg_cfg_reg.sv
`timescale 1ns/1ps
module irg_cfg_reg
   import irg_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      we,
   input  irg_ctrl_t wdata,
   output irg_ctrl_t ctrl
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ctrl <= IRG_CTRL_RST;
      else if (we) ctrl <= wdata;
   end
endmodule

// File: rtl/irg_echo_timer.sv
`timescale 1ns/1ps
module irg_echo_timer #(
   parameter int HOLD_CYC = 1600,
   parameter int CW       = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          led_on,
   output logic [CW-1:0] cnt,
   output logic          active
);
   localparam logic [CW-1:0] LOAD_V = CW'(HOLD_CYC);

   initial begin
      if (HOLD_CYC < 1) $error("irg_echo_timer: HOLD_CYC must be at least 1");
      if ((1 << CW) <= HOLD_CYC) $error("irg_echo_timer: CW too narrow");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (led_on)       cnt <= LOAD_V;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign active = led_on | (cnt != '0);
endmodule

// File: rtl/irg_first_sig_latch.sv
`timescale 1ns/1ps
module irg_first_sig_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_en,
   input  logic sig_valid,
   output logic seen,
   output logic open_now
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         seen <= 1'b0;
      else if (!rx_en)    seen <= 1'b0;
      else if (sig_valid) seen <= 1'b1;
   end

   assign open_now = seen | (rx_en & sig_valid);
endmodule

// File: rtl/irg_rx_gate.sv
`timescale 1ns/1ps
module irg_rx_gate #(
   parameter longint CLK_HZ  = 200_000_000,
   parameter int     HOLD_NS = 8000,
   parameter bit     REG_OUT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cfg_we,
   input  logic cfg_blank,
   input  logic cfg_remote,
   input  logic cfg_eager,
   input  logic rx_raw,
   input  logic led_on,
   input  logic sig_valid,
   input  logic rx_en,
   output logic rxd
);
   import irg_pkg::*;

   localparam int HOLD_CYC = int'((CLK_HZ * longint'(HOLD_NS) + 64'd999_999_999) / 64'd1_000_000_000);
   localparam int CW       = $clog2(HOLD_CYC + 1);

   initial begin
      if (CLK_HZ < 1_000_000) $error("irg_rx_gate: CLK_HZ below 1 MHz");
      if (HOLD_NS < 1)        $error("irg_rx_gate: HOLD_NS must be positive");
   end

   irg_ctrl_t     ctrl;
   irg_ctrl_t     wdata;
   logic [CW-1:0] hold_cnt;
   logic          led_window;
   logic          seen_q;
   logic          gate_open;
   logic          rxd_d;

   assign wdata = '{blank: cfg_blank, remote: cfg_remote, eager: cfg_eager};

   irg_cfg_reg u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (wdata),
      .ctrl  (ctrl)
   );

   irg_echo_timer #(.HOLD_CYC(HOLD_CYC), .CW(CW)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .led_on (led_on),
      .cnt    (hold_cnt),
      .active (led_window)
   );

   irg_first_sig_latch u_first (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_en     (rx_en),
      .sig_valid (sig_valid),
      .seen      (seen_q),
      .open_now  (gate_open)
   );

   always_comb begin
      if (!rx_en)                                      rxd_d = 1'b1;
      else if (ctrl.blank && led_window)               rxd_d = 1'b1;
      else if (ctrl.remote && !ctrl.eager && !gate_open) rxd_d = 1'b1;
      else                                             rxd_d = rx_raw;
   end

   generate
      if (REG_OUT) begin : g_reg
         logic rxd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rxd_q <= 1'b1;
            else        rxd_q <= rxd_d;
         end
         assign rxd = rxd_q;
      end else begin : g_comb
         assign rxd = rxd_d;
      end
   endgenerate
endmodule

// File: rtl/irg_rx_gate_chk.sv
`timescale 1ns/1ps
module irg_rx_gate_chk #(
   parameter int HOLD_CYC = 1600,
   parameter int CW       = 11,
   parameter bit REG_OUT  = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rx_raw,
   input logic          led_on,
   input logic          sig_valid,
   input logic          rx_en,
   input logic          rxd,
   input logic          blank_q,
   input logic          remote_q,
   input logic          eager_q,
   input logic [CW-1:0] hold_cnt,
   input logic          seen_q
);
   // R2/R3: timer reloads on any LED cycle and counts down by one otherwise
   assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
      led_on |=> hold_cnt == CW'(HOLD_CYC));
   assert_countdown_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!led_on && hold_cnt != '0) |=> hold_cnt == $past(hold_cnt) - 1'b1);
   // R8: disable re-arms the start gate
   assert_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> !seen_q);

   generate
      if (REG_OUT) begin : g_a
         assert_led_blank_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (blank_q && led_on) |=> rxd);
         assert_hold_blank_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (blank_q && hold_cnt != '0) |=> rxd);
         assert_disabled_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !rx_en |=> rxd);
         assert_wait_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_en && remote_q && !eager_q && !seen_q && !sig_valid) |=> rxd);
         assert_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_en && !blank_q && (!remote_q || eager_q)) |=> rxd == $past(rx_raw));
      end
   endgenerate
endmodule

bind irg_rx_gate irg_rx_gate_chk #(.HOLD_CYC(HOLD_CYC), .CW(CW), .REG_OUT(REG_OUT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_raw    (rx_raw),
   .led_on    (led_on),
   .sig_valid (sig_valid),
   .rx_en     (rx_en),
   .rxd       (rxd),
   .blank_q   (ctrl.blank),
   .remote_q  (ctrl.remote),
   .eager_q   (ctrl.eager),
   .hold_cnt  (hold_cnt),
   .seen_q    (seen_q)
);

// File: tb/tb_irg_rx_gate.sv
`timescale 1ns/1ps
module tb_irg_rx_gate;
   localparam int HOLD = 1600;   // 8 us at 200 MHz

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 0, cfg_blank = 0, cfg_remote = 0, cfg_eager = 0;
   logic rx_raw = 1, led_on = 0, sig_valid = 0, rx_en = 0;
   logic rxd;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // bench model state
   bit m_blank = 0, m_remote = 0, m_eager = 0, m_seen = 0;
   int m_cnt = 0;

   always #2.5 clk = ~clk;

   irg_rx_gate dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_blank(cfg_blank),
      .cfg_remote(cfg_remote), .cfg_eager(cfg_eager), .rx_raw(rx_raw),
      .led_on(led_on), .sig_valid(sig_valid), .rx_en(rx_en), .rxd(rxd)
   );

   function automatic bit exp_rxd(bit raw, bit led, bit valid, bit en);
      if (!en) return 1'b1;
      if (m_blank && (led || m_cnt != 0)) return 1'b1;
      if (m_remote && !m_eager && !m_seen && !valid) return 1'b1;
      return raw;
   endfunction

   task automatic check(bit act, bit exp, string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: rxd=%0b expected=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   // one cycle: drive at negedge, clock, check at next negedge
   task automatic step(bit raw, bit led, bit valid, bit en, string tag);
      bit e;
      rx_raw = raw; led_on = led; sig_valid = valid; rx_en = en;
      e = exp_rxd(raw, led, valid, en);
      @(posedge clk);
      m_cnt  = led ? HOLD : (m_cnt > 0 ? m_cnt - 1 : 0);
      m_seen = !en ? 1'b0 : (valid ? 1'b1 : m_seen);
      if (cfg_we) begin m_blank = cfg_blank; m_remote = cfg_remote; m_eager = cfg_eager; end
      @(negedge clk);
      cfg_we = 0;
      check(rxd, e, tag);
   endtask

   task automatic cfg(bit b, bit r, bit e);
      cfg_we = 1; cfg_blank = b; cfg_remote = r; cfg_eager = e;
      step(1'b0, 1'b0, 1'b0, 1'b1, "R10");
   endtask

   initial begin
      #900_000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1234_5678));
      #12;
      check(rxd, 1'b1, "R5 reset idle");
      @(negedge clk); rst_n = 1;

      // R5: control bits clear -> no blanking, no remote gate
      step(1'b0, 1'b1, 1'b0, 1'b1, "R5 ctrl clear");
      step(1'b0, 1'b1, 1'b0, 1'b1, "R4 pass during LED");
      step(1'b1, 1'b0, 1'b0, 1'b1, "R10 latency");
      step(1'b0, 1'b0, 1'b1, 1'b1, "R9 valid ignored");

      // R1/R2: exact end of recovery window
      cfg(1'b1, 1'b0, 1'b0);
      for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b0, 1'b1, "R1 LED blank");
      for (int i = 0; i < HOLD - 1; i++) step(1'b0, 1'b0, 1'b0, 1'b1, "R2 hold");
      step(1'b0, 1'b0, 1'b0, 1'b1, "R2 last blanked");
      check(rxd, 1'b1, "R2 last blanked edge");
      step(1'b0, 1'b0, 1'b0, 1'b1, "R2 first open");
      check(rxd, 1'b0, "R2 first open edge");

      // R3: re-light inside window restarts it
      step(1'b0, 1'b1, 1'b0, 1'b1, "R1");
      for (int i = 0; i < HOLD / 2; i++) step(1'b0, 1'b0, 1'b0, 1'b1, "R2");
      step(1'b0, 1'b1, 1'b0, 1'b1, "R3 relight");
      for (int i = 0; i < HOLD - 1; i++) step(1'b0, 1'b0, 1'b0, 1'b1, "R3 hold");
      step(1'b0, 1'b0, 1'b0, 1'b1, "R3 last");
      check(rxd, 1'b1, "R3 full window after relight");
      step(1'b0, 1'b0, 1'b0, 1'b1, "R3 open");
      check(rxd, 1'b0, "R3 open after full window");

      // R6/R8: remote wait for first valid, re-arm on disable
      cfg(1'b0, 1'b1, 1'b0);
      step(1'b0, 1'b0, 1'b0, 1'b0, "R8 disable");
      step(1'b0, 1'b0, 1'b0, 1'b1, "R6 waiting");
      check(rxd, 1'b1, "R6 idle before valid");
      step(1'b0, 1'b0, 1'b1, 1'b1, "R6 first valid");
      check(rxd, 1'b0, "R6 valid cycle passes");
      step(1'b0, 1'b0, 1'b0, 1'b1, "R6 after valid");
      step(1'b0, 1'b0, 1'b0, 1'b0, "R8 idle when disabled");
      step(1'b0, 1'b0, 1'b0, 1'b1, "R8 rearmed");
      check(rxd, 1'b1, "R8 rearmed gate holds idle");

      // R7: eager
      cfg(1'b0, 1'b1, 1'b1);
      step(1'b0, 1'b0, 1'b0, 1'b0, "R7");
      step(1'b0, 1'b0, 1'b0, 1'b1, "R7 eager passes");
      check(rxd, 1'b0, "R7 eager immediate");

      // random phases across all control combinations
      for (int ph = 0; ph < 12; ph++) begin
         bit led = 0, en = 1;
         cfg(1'($urandom), 1'($urandom), 1'($urandom));
         for (int c = 0; c < 3000; c++) begin
            if ($urandom_range(0, 399) == 0) led = ~led;
            if (led && $urandom_range(0, 99) == 0) led = 0;
            if ($urandom_range(0, 799) == 0) en = 0;
            else if (!en && $urandom_range(0, 3) == 0) en = 1;
            step(1'($urandom), led, ($urandom_range(0, 149) == 0), en, "R1-model/R4/R6/R9 random");
         end
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule